// File: doc/BRIEF.md
# Transposing and Bit-Reversing Row Address Sequencer

This block generates the memory addresses used to move one transform row between a large on-chip memory and a compute core during multi-pass FFTs. The memory holds a square array of N2 × N2 complex elements, where N2 is a power of four between 64 and 4096. A row transfer is launched with a start pulse that carries the direction, the pass number, the transform form (four-step long 1D or 2D), the row length, the row index and two base addresses. The block then issues one address per accepted beat on a ready/valid output, and it marks the final beat of the row.

Reads gather a row in one of two orders. The transposed order steps through memory at a stride of N2 elements. The contiguous order is used only for the first pass of a 2D transform. In the second pass of the four-step method, each data read is followed by a read of the matching twiddle factor from a separate array, so the read traffic doubles. Writes put the core's bit-reversed results back in natural order by reversing the low log2(N2) bits of the element counter. Transposition is always applied on the read side and is never folded into the writeback.

Top module: `fftag_addr_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid`, `out_last` and `out_tw` are 0.
- R2: A `start` pulse is taken only while `out_valid` is 0 and `len_log2` is one of 6, 8, 10 or 12. `out_valid` then rises in the next cycle. A `start` with any other `len_log2`, or a `start` during a running row, is ignored: no beat is issued for it and a running sequence continues unchanged.
- R3: A read with `form_2d`=0 and `pass_two`=0 issues N2 beats. Beat k (k = 0 … N2−1) has address `data_base` + k·N2 + `row_idx`.
- R4: A read with `form_2d`=1 and `pass_two`=0 issues N2 beats. Beat k has address `data_base` + `row_idx`·N2 + k.
- R5: A read with `form_2d`=1 and `pass_two`=1 uses the transposed addresses of R3 and issues no twiddle beats.
- R6: A read with `form_2d`=0 and `pass_two`=1 issues 2·N2 beats. Even beat 2k is the data address of R3 with `out_tw`=0. Odd beat 2k+1 has address `tw_base` + `row_idx`·N2 + k with `out_tw`=1.
- R7: A write (`op_write`=1), in any pass and form, issues N2 beats. Beat k has address `data_base` + `row_idx`·N2 + rev(k), where rev reverses bits [log2(N2)−1:0] of k. `out_tw` stays 0.
- R8: `out_last` is 1 only on the final beat of the row. After that beat is accepted, `out_valid` is 0 in the next cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, the sequence does not advance, and `out_addr`, `out_last` and `out_tw` hold their values.
- R10: Address sums wrap modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one row transfer |
| op_write | input | 1 | 1 = bit-reversed writeback, 0 = read |
| pass_two | input | 1 | 1 = second pass, 0 = first pass |
| form_2d | input | 1 | 1 = 2D transform, 0 = four-step 1D transform |
| len_log2 | input | 4 | log2 of the row length N2 |
| row_idx | input | 12 | Row being moved |
| data_base | input | 24 | Base address of the data array |
| tw_base | input | 24 | Base address of the twiddle array |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A beat is presented |
| out_addr | output | 24 | Memory address of the beat |
| out_last | output | 1 | Final beat of the row |
| out_tw | output | 1 | Beat reads a twiddle factor |

## Verification
The assertions rely on the inputs being steady while `start` is high, and they treat `out_ready` as free to change on any cycle. In stall cycles they expect only the hold behaviour and no other property of the consumer. The stimulus drives `out_ready` low at random at different rates, and it fires `start` pulses that should be ignored in the middle of running rows and with odd or out-of-range lengths. Row indices are kept below N2, as a real row sweep would keep them. Base addresses near the top of the 24-bit space exercise the wrap.

// File: rtl/fftag_pkg.sv
package fftag_pkg;

    localparam int ADDR_W = 24;
    localparam int LG_MIN = 6;
    localparam int LG_MAX = 12;
    localparam int LG_W   = 4;
    localparam int IDX_W  = LG_MAX;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } xfer_op_e;

    typedef struct packed {
        xfer_op_e            op;
        logic                pass2;
        logic                form2d;
        logic [LG_W-1:0]     lg;
        logic [IDX_W-1:0]    row;
        logic [ADDR_W-1:0]   dbase;
        logic [ADDR_W-1:0]   tbase;
    } xfer_cfg_t;

    // Only even exponents in range name a power-of-four row length.
    function automatic logic len_ok(input logic [LG_W-1:0] lg);
        return (int'(lg) >= LG_MIN) && (int'(lg) <= LG_MAX) && !lg[0];
    endfunction

    // Twiddle reads ride along only on the second pass of a long 1D read.
    function automatic logic wants_twiddle(input xfer_cfg_t c);
        return (c.op == OP_READ) && c.pass2 && !c.form2d;
    endfunction

    // Reverse the low lg bits of k; upper bits come out zero.
    function automatic logic [IDX_W-1:0] rev_low(input logic [IDX_W-1:0] k,
                                                 input logic [LG_W-1:0]  lg);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < IDX_W; i++) begin
            if (i < int'(lg)) begin
                r[i] = k[int'(lg) - 1 - i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fftag_beat_seq.sv
module fftag_beat_seq #(
    parameter int KW = 12,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          il,
    input  logic [LW-1:0] lg,
    input  logic          ready,
    output logic          active,
    output logic [KW-1:0] k,
    output logic          tw_ph,
    output logic          last
);

    logic [KW:0]   span;
    logic [KW-1:0] kmax;

    always_comb begin
        span = (KW+1)'(1) << lg;
        kmax = span[KW-1:0] - 1'b1;
        last = active && (k == kmax) && (!il || tw_ph);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            k      <= '0;
            tw_ph  <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
            k      <= '0;
            tw_ph  <= 1'b0;
        end else if (active && ready) begin
            if (last) begin
                active <= 1'b0;
            end
            if (il && !tw_ph) begin
                tw_ph <= 1'b1;
            end else begin
                tw_ph <= 1'b0;
                k     <= k + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fftag_addr_map.sv
module fftag_addr_map
    import fftag_pkg::*;
#(
    parameter int AW = 24,
    parameter int KW = 12
) (
    input  xfer_cfg_t     cfg,
    input  logic [KW-1:0] k,
    input  logic          tw_ph,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] row_ofs;
    logic [AW-1:0] k_stride;
    logic [AW-1:0] k_rev;

    always_comb begin
        row_ofs  = AW'(cfg.row) << cfg.lg;
        k_stride = AW'(k) << cfg.lg;
        k_rev    = AW'(rev_low(IDX_W'(k), cfg.lg));
        if (tw_ph) begin
            addr = cfg.tbase + row_ofs + AW'(k);
        end else if (cfg.op == OP_WRITE) begin
            addr = cfg.dbase + row_ofs + k_rev;
        end else if (cfg.form2d && !cfg.pass2) begin
            addr = cfg.dbase + row_ofs + AW'(k);
        end else begin
            addr = cfg.dbase + k_stride + AW'(cfg.row);
        end
    end

endmodule

// File: rtl/fftag_addr_gen.sv
module fftag_addr_gen
    import fftag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_write,
    input  logic              pass_two,
    input  logic              form_2d,
    input  logic [LG_W-1:0]   len_log2,
    input  logic [IDX_W-1:0]  row_idx,
    input  logic [ADDR_W-1:0] data_base,
    input  logic [ADDR_W-1:0] tw_base,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_last,
    output logic              out_tw
);

    xfer_cfg_t         cfg_q;
    logic              take;
    logic              tw_mode;
    logic              active;
    logic [IDX_W-1:0]  k;
    logic              tw_ph;
    logic              last;

    assign take    = start && !active && len_ok(len_log2);
    assign tw_mode = wants_twiddle(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (take) begin
            cfg_q.op     <= op_write ? OP_WRITE : OP_READ;
            cfg_q.pass2  <= pass_two;
            cfg_q.form2d <= form_2d;
            cfg_q.lg     <= len_log2;
            cfg_q.row    <= row_idx;
            cfg_q.dbase  <= data_base;
            cfg_q.tbase  <= tw_base;
        end
    end

    fftag_beat_seq #(.KW(IDX_W), .LW(LG_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .il     (tw_mode),
        .lg     (cfg_q.lg),
        .ready  (out_ready),
        .active (active),
        .k      (k),
        .tw_ph  (tw_ph),
        .last   (last)
    );

    fftag_addr_map #(.AW(ADDR_W), .KW(IDX_W)) u_map (
        .cfg   (cfg_q),
        .k     (k),
        .tw_ph (tw_ph),
        .addr  (out_addr)
    );

    assign out_valid = active;
    assign out_last  = last;
    assign out_tw    = active && tw_ph;

endmodule

// File: rtl/fftag_addr_gen_chk.sv
module fftag_addr_gen_chk
    import fftag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [LG_W-1:0]   len_log2,
    input logic              out_ready,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_last,
    input logic              out_tw,
    input logic              il
);

    AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && start && !len_ok(len_log2)) |=> !out_valid); // R2

    AST_START_RAISES_VALID: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && start && len_ok(len_log2)) |=> out_valid); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_addr) && $stable(out_last) && $stable(out_tw))); // R9

    AST_LAST_ENDS_ROW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid); // R8

    AST_TW_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && il && !out_last) |=> (out_tw != $past(out_tw))); // R6

    AST_NO_TW_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !il) |-> !out_tw); // R7

endmodule

bind fftag_addr_gen fftag_addr_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .len_log2  (len_log2),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_last  (out_last),
    .out_tw    (out_tw),
    .il        (tw_mode)
);

// File: tb/fftag_addr_gen_test.sv
module fftag_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_write = 1'b0;
    logic        pass_two = 1'b0;
    logic        form_2d = 1'b0;
    logic [3:0]  len_log2 = 4'd6;
    logic [11:0] row_idx = '0;
    logic [23:0] data_base = '0;
    logic [23:0] tw_base = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [23:0] out_addr;
    logic        out_last;
    logic        out_tw;

    int checks = 0;
    int errors = 0;

    // model copy of the row under test
    logic        m_wr, m_p2, m_2d;
    int          m_lg;
    logic [11:0] m_row;
    logic [23:0] m_db, m_tb;

    fftag_addr_gen uut (
        .clk(clk), .rst(rst), .start(start), .op_write(op_write),
        .pass_two(pass_two), .form_2d(form_2d), .len_log2(len_log2),
        .row_idx(row_idx), .data_base(data_base), .tw_base(tw_base),
        .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
        .out_last(out_last), .out_tw(out_tw)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: act=timeout exp=finish");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] rev_bits(input int k, input int lg);
        logic [23:0] r = '0;
        for (int i = 0; i < lg; i++) r[lg-1-i] = k[i];
        return r;
    endfunction

    function automatic bit model_il();
        return !m_wr && m_p2 && !m_2d;
    endfunction

    // {valid,last,tw,addr} expected for beat i of a row
    function automatic logic [31:0] model_beat(input int i);
        int n = 1 << m_lg;
        int k;
        bit tw;
        bit lst;
        logic [23:0] a;
        if (model_il()) begin
            k = i / 2; tw = (i % 2) == 1; lst = (i == 2*n - 1);
        end else begin
            k = i; tw = 1'b0; lst = (i == n - 1);
        end
        if (tw)              a = m_tb + 24'(m_row * n) + 24'(k);
        else if (m_wr)       a = m_db + 24'(m_row * n) + rev_bits(k, m_lg);
        else if (m_2d && !m_p2) a = m_db + 24'(m_row * n) + 24'(k);
        else                 a = m_db + 24'(k * n) + 24'(m_row);
        return {5'b0, 1'b1, lst, tw, a};
    endfunction

    function automatic logic [31:0] dut_beat();
        return {5'b0, out_valid, out_last, out_tw, out_addr};
    endfunction

    // Runs one row; called and returns at a negedge.
    task automatic run_row(input bit wr, input bit p2, input bit f2, input int lg,
                           input logic [11:0] row, input logic [23:0] db, input logic [23:0] tb,
                           input int stall_pct, input bit poke, input string tag);
        int n;
        int idx = 0;
        bit prev_rdy = 1'b1;
        logic [31:0] e;
        m_wr = wr; m_p2 = p2; m_2d = f2; m_lg = lg; m_row = row; m_db = db; m_tb = tb;
        op_write = wr; pass_two = p2; form_2d = f2; len_log2 = 4'(lg);
        row_idx = row; data_base = db; tw_base = tb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = model_il() ? 2 * (1 << lg) : (1 << lg);
        while (idx < n) begin
            e = model_beat(idx);
            chk(dut_beat() == e, prev_rdy ? tag : {tag, " R9 stall"}, dut_beat(), e);
            out_ready = ($urandom % 100) >= stall_pct;
            if (poke && idx == 3) begin
                // R2: a start during a running row must be ignored
                start = 1'b1; op_write = ~wr; pass_two = ~p2; len_log2 = 4'd8;
                row_idx = 12'h5a; data_base = 24'h123456;
            end else begin
                start = 1'b0;
            end
            prev_rdy = out_ready;
            if (out_ready) idx++;
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R8 valid drops after last", {31'b0, out_valid}, 32'h0);
    endtask

    task automatic bad_start(input logic [3:0] lg);
        len_log2 = lg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin
            chk(out_valid == 1'b0, "R2 bad length ignored", {31'b0, out_valid}, 32'h0);
            @(negedge clk);
        end
    endtask

    function automatic string tag_for(input bit wr, input bit p2, input bit f2);
        if (wr) return "R7";
        if (p2 && !f2) return "R6";
        if (f2 && !p2) return "R4";
        if (f2 && p2) return "R5";
        return "R3";
    endfunction

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk({out_valid, out_last, out_tw} == 3'b000, "R1 during reset",
            {29'b0, out_valid, out_last, out_tw}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk({out_valid, out_last, out_tw} == 3'b000, "R1 after reset",
            {29'b0, out_valid, out_last, out_tw}, 32'h0);

        // directed corners
        run_row(0, 0, 0, 6,  12'd5,  24'h001000, 24'h0, 0,  0, "R3");
        run_row(0, 0, 1, 6,  12'd7,  24'h020000, 24'h0, 0,  0, "R4");
        run_row(0, 1, 1, 6,  12'd63, 24'h030000, 24'h0, 30, 0, "R5");
        run_row(0, 1, 0, 6,  12'd9,  24'h040000, 24'h800000, 40, 0, "R6");
        run_row(1, 0, 0, 6,  12'd3,  24'h050000, 24'h0, 0,  0, "R7");
        run_row(1, 1, 1, 12, 12'd4095, 24'h000000, 24'h0, 0, 0, "R7 n4096");
        run_row(0, 0, 0, 12, 12'd1,  24'h000000, 24'h0, 0,  0, "R3 n4096");
        run_row(0, 1, 0, 8,  12'd200, 24'hFFFFF0, 24'hFFFF00, 20, 0, "R10 wrap");
        run_row(1, 0, 1, 8,  12'd255, 24'hFFFF80, 24'h0, 0, 0, "R10 wrap");
        run_row(0, 0, 1, 6,  12'd2,  24'h060000, 24'h0, 10, 1, "R2 ignored start");
        run_row(0, 1, 0, 6,  12'd1,  24'h070000, 24'h090000, 10, 1, "R2 ignored start");
        bad_start(4'd7);
        bad_start(4'd4);
        bad_start(4'd14);
        bad_start(4'd0);

        // constrained random rows
        for (int t = 0; t < 40; t++) begin
            bit wr = $urandom % 2;
            bit p2 = $urandom % 2;
            bit f2 = $urandom % 2;
            int lg = 6 + 2 * ($urandom % 3);
            logic [11:0] row = 12'($urandom) & 12'((1 << lg) - 1);
            run_row(wr, p2, f2, lg, row, 24'($urandom), 24'($urandom),
                    $urandom % 50, 1'($urandom % 4 == 0), tag_for(wr, p2, f2));
        end

        summary();
        $finish;
    end

endmodule